// File: doc/BRIEF.md
# Configurable UART Serial Transmitter

This block turns one parallel character into an asynchronous serial frame. The frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop interval. Each bit lasts a fixed number of pulses of a 16x-rate clock enable, which a baud generator elsewhere in the chip supplies. The serial line rests high between frames.

The host presents a byte and a load strobe while `ready` is high. The character length, parity mode and stop setting are captured with the byte, so they may change while a frame is on the line. A break control pulls the line low at any time. The frame sequencer keeps counting during a break, so `ready` returns on the same schedule as it would without one.

Top module: `uart_tx_core`

## Requirements
- R1: After reset and whenever no frame is in progress, `ready` is 1 and `txd` is 1 (unless `brk` is 1).
- R2: A `load` sampled while `ready` is 1 starts a frame: `ready` goes to 0 and `txd` goes low at that clock edge, and the start bit lasts `TICKS_PER_BIT` (16) tick pulses.
- R3: Data bits follow the start bit least significant bit first, each lasting 16 ticks. The number of data bits is set by `len_sel` (00=5, 01=6, 10=7, 11=8). Bits of `din` above the selected length are not sent.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0, the data bits plus the parity bit hold an even number of ones; with `par_odd`=1, they hold an odd number. When `par_en` is 0, no parity bit is sent.
- R5: The stop interval is high and lasts 16 ticks when `stop_sel`=0. When `stop_sel`=1, it lasts 24 ticks for a 5-bit length and 32 ticks for 6 to 8 bits. `ready` returns to 1 on the last tick of the stop interval.
- R6: While `brk` is 1, `txd` is 0. Frame timing and `ready` are unaffected.
- R7: A `load` while `ready` is 0 is ignored. The frame in progress continues unchanged.
- R8: Clock cycles without `tick` do not advance the frame. `txd` and `ready` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 16x-rate bit-timing enable, one cycle per pulse |
| load | input | 1 | Accept `din` and the line settings and start a frame |
| din | input | 8 | Character to send |
| len_sel | input | 2 | Data length: 00=5, 01=6, 10=7, 11=8 bits |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_sel | input | 1 | 0 = one stop bit, 1 = 1.5 (5-bit length) or 2 stop bits |
| brk | input | 1 | Force the line to the low (spacing) state |
| txd | output | 1 | Serial output |
| ready | output | 1 | 1 when idle and able to accept a load |

## Verification
The bench builds the block with its default of 16 ticks per bit. With that value, the 24-tick stop interval of 1.5 stop bits ends on a half-bit boundary, and the bench checks that boundary against the 16-tick and 32-tick cases. Random gaps of zero to two cycles between ticks show that idle cycles never advance the frame. Random lengths, parity modes and data run alongside directed frames for break and for a load made in the middle of a frame.

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop_sel,
  input  logic       brk,
  output logic       txd,
  output logic       ready
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CW-1:0] LAST_ONE  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] LAST_HALF = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CW-1:0] LAST_TWO  = CW'(2 * TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic [1:0]    len_q;
  logic          par_en_q, par_bit_q, stop_q;
  logic          line;
  logic [CW-1:0] last_cnt;

  wire [7:0] mask     = 8'hFF >> (2'd3 - len_sel);
  wire       last_bit = idx == ({1'b0, len_q} + 3'd4);
  wire       at_end   = cnt == last_cnt;

  always_comb begin
    if (st == S_STOP && stop_q) last_cnt = (len_q == 2'd0) ? LAST_HALF : LAST_TWO;
    else                        last_cnt = LAST_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      len_q     <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop_q    <= 1'b0;
    end else if (st == S_IDLE) begin
      if (load) begin
        st        <= S_START;
        cnt       <= '0;
        idx       <= '0;
        sh        <= din & mask;
        len_q     <= len_sel;
        par_en_q  <= par_en;
        par_bit_q <= ^(din & mask) ^ par_odd;
        stop_q    <= stop_sel;
      end
    end else if (tick) begin
      if (!at_end) cnt <= cnt + 1'b1;
      else begin
        cnt <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh <= sh >> 1;
            if (last_bit) st <= par_en_q ? S_PAR : S_STOP;
            else          idx <= idx + 3'd1;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = sh[0];
      S_PAR:   line = par_bit_q;
      default: line = 1'b1;
    endcase
  end

  assign txd   = line & ~brk;
  assign ready = st == S_IDLE;

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !brk |-> txd);                                             // R1
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && load |=> !ready && !line);                                 // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_START |-> !txd);                                            // R2
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);                                                      // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && load |=> $stable(len_q) && $stable(par_bit_q) && $stable(stop_q)); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !tick |=> $stable(cnt) && $stable(ready) && $stable(line)); // R8
endmodule

// File: tb/sim_uart_tx_core.sv
module sim_uart_tx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, load = 1'b0;
  logic [7:0] din = '0;
  logic [1:0] len_sel = '0;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_sel = 1'b0, brk = 1'b0;
  logic       txd, ready;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_core u0 (.clk, .rst_n, .tick, .load, .din, .len_sel, .par_en,
                   .par_odd, .stop_sel, .brk, .txd, .ready);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic frame_bit(input logic [7:0] d, input int n,
                                     input logic pe, input logic po, input int k);
    logic [7:0] m = 8'hFF >> (8 - n);
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (pe && k == n + 1) return (^(d & m)) ^ po;
    return 1'b1;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] l, input logic pe,
                      input logic po, input logic s2, input logic b, input logic busy_load);
    int n = int'(l) + 5;
    int stop_t = !s2 ? 16 : (l == 2'd0 ? 24 : 32);
    int total = 16 * (1 + n + int'(pe)) + stop_t;
    logic exp_txd, exp_rdy;
    @(negedge clk);
    din = d; len_sel = l; par_en = pe; par_odd = po; stop_sel = s2; brk = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    din = 8'($urandom); len_sel = 2'($urandom); par_en = 1'($urandom);
    par_odd = 1'($urandom); stop_sel = 1'($urandom);
    exp_txd = 1'b0; exp_rdy = 1'b0;
    check("R2 start bit low", txd, 1'b0);
    check("R2 ready drops", ready, 1'b0);
    for (int j = 1; j <= total; j++) begin
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        check("R8 hold txd", txd, exp_txd);
        check("R8 hold ready", ready, exp_rdy);
      end
      tick = 1'b1;
      if (busy_load && (j == total / 2 || j == 20)) begin load = 1'b1; din = ~d; end
      @(negedge clk);
      tick = 1'b0; load = 1'b0;
      exp_rdy = (j == total);
      exp_txd = b ? 1'b0 : (exp_rdy ? 1'b1 : frame_bit(d, n, pe, po, j / 16));
      if (j < 16)                   check("R2 start bit", txd, exp_txd);
      else if (j < 16 * (1 + n))    check("R3 data bit", txd, exp_txd);
      else if (j < 16 * (1 + n + int'(pe))) check("R4 parity bit", txd, exp_txd);
      else                          check(b ? "R6 break low" : "R5 stop bit", txd, exp_txd);
      check(busy_load ? "R7 ready after ignored load" : "R5 ready timing", ready, exp_rdy);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset txd", txd, 1'b1);
    check("R1 reset ready", ready, 1'b1);
    rst_n = 1'b1;
    void'($urandom(32'd1234));
    for (int l = 0; l < 4; l++) send(8'hA5, 2'(l), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R3
    send(8'h13, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // R4 even
    send(8'h13, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R4 odd
    send(8'hFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);   // R5 1.5 stop
    send(8'h00, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);   // R5 2 stop
    send(8'h5A, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);   // R6 break
    @(negedge clk); brk = 1'b1;
    @(negedge clk); check("R6 idle break low", txd, 1'b0);
    brk = 1'b0;
    @(negedge clk); check("R1 idle high after break", txd, 1'b1);
    send(8'hC3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);   // R7
    for (int i = 0; i < 40; i++)
      send(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 9) == 0), 1'($urandom_range(0, 3) == 0));
    repeat (3) @(negedge clk);
    check("R1 final ready", ready, 1'b1);
    check("R1 final txd", txd, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule